// File: doc/BRIEF.md
# Paired-Page Translation Lookup

This block is a fully associative address translation cache. Each entry describes a naturally aligned pair of virtual pages: an even half and an odd half that share one tag. The tag is made of a virtual page-pair number, a size mask, an 8-bit address-space identifier, a global flag and a hardware-kill flag. Each half carries its own physical frame base and four permission flags: valid, dirty (writable), read-inhibit and execute-inhibit.

A lookup presents a virtual address, an access kind and the current address-space identifier. In the same cycle the block returns a result code, the physical address and a write-permission flag. The result code tells the exception logic which fault, if any, the access raised. Entries are loaded through a simple indexed write port, and a write takes effect at the next clock edge. Replacement policy and fault handling belong to the surrounding logic.

Top module: `tlbpp_lookup`

## Requirements
- R1: After reset every entry is disabled, so any lookup returns NOMATCH (code 1) with `lk_paddr` = 0 and `lk_writable` = 0.
- R2: An entry takes part in a lookup only when its kill flag is clear and either its global flag is set or its identifier equals `lk_asid`. Otherwise it is skipped.
- R3: The effective mask is the entry size mask ORed with the low 13 address bits. Address bits under the effective mask take no part in the tag compare.
- R4: The half is odd when the address bit at the top set position of the effective mask is 1, and even otherwise. With a zero size mask that bit is bit 12.
- R5: On a tag hit whose selected half has valid = 0, the result is INVALID (code 2), whatever the access kind.
- R6: A fetch (`lk_acc` = 0) to a valid half with execute-inhibit set gives XI (code 5). A load (`lk_acc` = 1) to a valid half with read-inhibit set gives RI (code 4). A fetch ignores read-inhibit, a load ignores execute-inhibit, and a store (`lk_acc` = 2) ignores both.
- R7: A store to a valid half whose dirty flag is clear gives DIRTY (code 3).
- R8: On MATCH (code 0) the physical address is the selected frame base ORed with the address bits under the effective mask shifted right by one. On any other result it is 0.
- R9: `lk_writable` is 1 only on MATCH, and then equals the selected dirty flag, for all access kinds.
- R10: When several entries hit, the entry with the lowest index decides the result.
- R11: With `wr_en` = 1 at a clock edge, entry `wr_idx` is replaced by the write fields. Flag bits in `wr_flags_*` are [0] valid, [1] dirty, [2] read-inhibit, [3] execute-inhibit. The new entry is seen by lookups after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 32 | Virtual page-pair tag |
| wr_pmask | input | 32 | Size mask, ones above bit 12 widen the pair |
| wr_asid | input | 8 | Address-space identifier |
| wr_global | input | 1 | Match any identifier |
| wr_hkill | input | 1 | Hardware-kill: entry never matches |
| wr_pfn_even | input | 32 | Physical base of the even half |
| wr_pfn_odd | input | 32 | Physical base of the odd half |
| wr_flags_even | input | 4 | Even half flags |
| wr_flags_odd | input | 4 | Odd half flags |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | 0 fetch, 1 load, 2 store |
| lk_asid | input | 8 | Current address-space identifier |
| lk_result | output | 3 | Result code |
| lk_paddr | output | 32 | Translated address, 0 unless MATCH |
| lk_writable | output | 1 | Write permission of the selected half |

## Verification
Directed lookups cover several cases: a small pair hit on each half, an identifier mismatch against a global entry, a wide pair where bits 13 to 15 change but the tag still hits, a killed entry, and two overlapping entries that show which index wins. Each of these separates one rule of the compare or the half selection from its neighbours. The permission cases run every access kind against halves that carry read-inhibit, execute-inhibit or a clear dirty flag. This shows that each fault code comes only from its own flag and access kind. A random phase then mixes rewrites with lookups over a small address window, so hits, misses, overlaps and both mask sizes occur often. Each random lookup is compared with a reference model in the bench.

// File: rtl/tlbpp_pkg.sv
package tlbpp_pkg;

   // Result code of a lookup, consumed by the fault logic downstream
   typedef enum logic [2:0] {
      RES_MATCH   = 3'd0,
      RES_NOMATCH = 3'd1,
      RES_INVALID = 3'd2,
      RES_DIRTY   = 3'd3,
      RES_RINH    = 3'd4,
      RES_XINH    = 3'd5
   } tlb_res_e;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2
   } tlb_acc_e;

   // Per-half permission flags; bit 0 is valid
   typedef struct packed {
      logic xinh;
      logic rinh;
      logic dirty;
      logic valid;
   } half_flags_t;

endpackage

// File: rtl/tlbpp_entry_store.sv
module tlbpp_entry_store
   import tlbpp_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int ASID_W      = 8,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VA_W-1:0]   wr_vpn,
   input  logic [VA_W-1:0]   wr_pmask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic              wr_hkill,
   input  logic [PA_W-1:0]   wr_pfn_even,
   input  logic [PA_W-1:0]   wr_pfn_odd,
   input  half_flags_t       wr_fl_even,
   input  half_flags_t       wr_fl_odd,
   output logic [VA_W-1:0]   e_vpn      [NUM_ENTRIES],
   output logic [VA_W-1:0]   e_pmask    [NUM_ENTRIES],
   output logic [ASID_W-1:0] e_asid     [NUM_ENTRIES],
   output logic              e_global   [NUM_ENTRIES],
   output logic              e_hkill    [NUM_ENTRIES],
   output logic [PA_W-1:0]   e_pfn_even [NUM_ENTRIES],
   output logic [PA_W-1:0]   e_pfn_odd  [NUM_ENTRIES],
   output half_flags_t       e_fl_even  [NUM_ENTRIES],
   output half_flags_t       e_fl_odd   [NUM_ENTRIES]
);

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
      logic sel_w;
      assign sel_w = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            e_vpn[g]      <= '0;
            e_pmask[g]    <= '0;
            e_asid[g]     <= '0;
            e_global[g]   <= 1'b0;
            e_hkill[g]    <= 1'b1;
            e_pfn_even[g] <= '0;
            e_pfn_odd[g]  <= '0;
            e_fl_even[g]  <= '0;
            e_fl_odd[g]   <= '0;
         end else if (sel_w) begin
            e_vpn[g]      <= wr_vpn;
            e_pmask[g]    <= wr_pmask;
            e_asid[g]     <= wr_asid;
            e_global[g]   <= wr_global;
            e_hkill[g]    <= wr_hkill;
            e_pfn_even[g] <= wr_pfn_even;
            e_pfn_odd[g]  <= wr_pfn_odd;
            e_fl_even[g]  <= wr_fl_even;
            e_fl_odd[g]   <= wr_fl_odd;
         end
      end
   end

   // R11: a write lands in the addressed slot at the next edge
   a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (e_vpn[$past(wr_idx)] == $past(wr_vpn)) &&
                (e_pfn_odd[$past(wr_idx)] == $past(wr_pfn_odd)));

endmodule

// File: rtl/tlbpp_match.sv
module tlbpp_match #(
   parameter int NUM_ENTRIES    = 16,
   parameter int VA_W           = 32,
   parameter int ASID_W         = 8,
   parameter int PAIR_LOW_BITS  = 13
) (
   input  logic [VA_W-1:0]        lk_vaddr,
   input  logic [ASID_W-1:0]      lk_asid,
   input  logic [VA_W-1:0]        e_vpn    [NUM_ENTRIES],
   input  logic [VA_W-1:0]        e_pmask  [NUM_ENTRIES],
   input  logic [ASID_W-1:0]      e_asid   [NUM_ENTRIES],
   input  logic                   e_global [NUM_ENTRIES],
   input  logic                   e_hkill  [NUM_ENTRIES],
   output logic [NUM_ENTRIES-1:0] hit_vec,
   output logic [VA_W-1:0]        e_emask  [NUM_ENTRIES]
);

   localparam logic [VA_W-1:0] LOW_MASK = VA_W'((64'd1 << PAIR_LOW_BITS) - 64'd1);

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
      logic id_ok;
      logic tag_ok;
      assign e_emask[g] = e_pmask[g] | LOW_MASK;
      assign id_ok      = e_global[g] || (e_asid[g] == lk_asid);
      assign tag_ok     = ((lk_vaddr ^ e_vpn[g]) & ~e_emask[g]) == '0;
      assign hit_vec[g] = id_ok && tag_ok && !e_hkill[g];
   end

endmodule

// File: rtl/tlbpp_pick.sv
module tlbpp_pick #(
   parameter int NUM_ENTRIES = 16,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic [NUM_ENTRIES-1:0] hit_vec,
   output logic [NUM_ENTRIES-1:0] sel_oh,
   output logic [IDX_W-1:0]       sel_idx,
   output logic                   any_hit
);

   // Lowest index wins: scan from the top so the last write is the lowest hit
   always_comb begin
      sel_idx = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) sel_idx = IDX_W'(i);
      end
   end

   assign any_hit = |hit_vec;
   assign sel_oh  = any_hit ? (NUM_ENTRIES'(1) << sel_idx) : '0;

endmodule

// File: rtl/tlbpp_perm.sv
module tlbpp_perm
   import tlbpp_pkg::*;
#(
   parameter int VA_W = 32,
   parameter int PA_W = 32
) (
   input  logic              any_hit,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic [1:0]        lk_acc,
   input  logic [VA_W-1:0]   s_emask,
   input  logic [PA_W-1:0]   s_pfn_even,
   input  logic [PA_W-1:0]   s_pfn_odd,
   input  half_flags_t       s_fl_even,
   input  half_flags_t       s_fl_odd,
   output tlb_res_e          res,
   output logic [PA_W-1:0]   paddr,
   output logic              writable
);

   logic [VA_W-1:0] half_bit;
   logic [VA_W-1:0] off;
   logic            odd;
   half_flags_t     fl;
   logic [PA_W-1:0] base;

   assign half_bit = s_emask & ~(s_emask >> 1);
   assign odd      = |(lk_vaddr & half_bit);
   assign fl       = odd ? s_fl_odd : s_fl_even;
   assign base     = odd ? s_pfn_odd : s_pfn_even;
   assign off      = lk_vaddr & (s_emask >> 1);

   always_comb begin
      res = RES_MATCH;
      if (!any_hit)                                  res = RES_NOMATCH;
      else if (!fl.valid)                            res = RES_INVALID;
      else if (lk_acc == ACC_FETCH && fl.xinh)       res = RES_XINH;
      else if (lk_acc == ACC_LOAD && fl.rinh)        res = RES_RINH;
      else if (lk_acc == ACC_STORE && !fl.dirty)     res = RES_DIRTY;
   end

   assign paddr    = (res == RES_MATCH) ? (base | PA_W'(off)) : '0;
   assign writable = (res == RES_MATCH) && fl.dirty;

endmodule

// File: rtl/tlbpp_lookup.sv
module tlbpp_lookup
   import tlbpp_pkg::*;
#(
   parameter int NUM_ENTRIES   = 16,
   parameter int VA_W          = 32,
   parameter int PA_W          = 32,
   parameter int ASID_W        = 8,
   parameter int PAIR_LOW_BITS = 13,
   localparam int IDX_W        = $clog2(NUM_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VA_W-1:0]   wr_vpn,
   input  logic [VA_W-1:0]   wr_pmask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic              wr_hkill,
   input  logic [PA_W-1:0]   wr_pfn_even,
   input  logic [PA_W-1:0]   wr_pfn_odd,
   input  logic [3:0]        wr_flags_even,
   input  logic [3:0]        wr_flags_odd,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic [1:0]        lk_acc,
   input  logic [ASID_W-1:0] lk_asid,
   output logic [2:0]        lk_result,
   output logic [PA_W-1:0]   lk_paddr,
   output logic              lk_writable
);

   if (NUM_ENTRIES < 2) begin : g_bad_n
      $error("tlbpp_lookup: NUM_ENTRIES must be at least 2");
   end
   if (PAIR_LOW_BITS < 2 || PAIR_LOW_BITS >= VA_W) begin : g_bad_low
      $error("tlbpp_lookup: PAIR_LOW_BITS out of range");
   end
   if (ASID_W < 1) begin : g_bad_asid
      $error("tlbpp_lookup: ASID_W must be positive");
   end

   logic [VA_W-1:0]   e_vpn      [NUM_ENTRIES];
   logic [VA_W-1:0]   e_pmask    [NUM_ENTRIES];
   logic [ASID_W-1:0] e_asid     [NUM_ENTRIES];
   logic              e_global   [NUM_ENTRIES];
   logic              e_hkill    [NUM_ENTRIES];
   logic [PA_W-1:0]   e_pfn_even [NUM_ENTRIES];
   logic [PA_W-1:0]   e_pfn_odd  [NUM_ENTRIES];
   half_flags_t       e_fl_even  [NUM_ENTRIES];
   half_flags_t       e_fl_odd   [NUM_ENTRIES];
   logic [VA_W-1:0]   e_emask    [NUM_ENTRIES];

   logic [NUM_ENTRIES-1:0] hit_vec;
   logic [NUM_ENTRIES-1:0] sel_oh;
   logic [IDX_W-1:0]       sel_idx;
   logic                   any_hit;
   tlb_res_e               res;

   tlbpp_entry_store #(
      .NUM_ENTRIES(NUM_ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_vpn(wr_vpn), .wr_pmask(wr_pmask), .wr_asid(wr_asid),
      .wr_global(wr_global), .wr_hkill(wr_hkill),
      .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
      .wr_fl_even(half_flags_t'(wr_flags_even)),
      .wr_fl_odd(half_flags_t'(wr_flags_odd)),
      .e_vpn(e_vpn), .e_pmask(e_pmask), .e_asid(e_asid),
      .e_global(e_global), .e_hkill(e_hkill),
      .e_pfn_even(e_pfn_even), .e_pfn_odd(e_pfn_odd),
      .e_fl_even(e_fl_even), .e_fl_odd(e_fl_odd)
   );

   tlbpp_match #(
      .NUM_ENTRIES(NUM_ENTRIES), .VA_W(VA_W), .ASID_W(ASID_W),
      .PAIR_LOW_BITS(PAIR_LOW_BITS)
   ) u_match (
      .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
      .e_vpn(e_vpn), .e_pmask(e_pmask), .e_asid(e_asid),
      .e_global(e_global), .e_hkill(e_hkill),
      .hit_vec(hit_vec), .e_emask(e_emask)
   );

   tlbpp_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
      .hit_vec(hit_vec), .sel_oh(sel_oh), .sel_idx(sel_idx), .any_hit(any_hit)
   );

   tlbpp_perm #(.VA_W(VA_W), .PA_W(PA_W)) u_perm (
      .any_hit(any_hit), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
      .s_emask(e_emask[sel_idx]),
      .s_pfn_even(e_pfn_even[sel_idx]), .s_pfn_odd(e_pfn_odd[sel_idx]),
      .s_fl_even(e_fl_even[sel_idx]), .s_fl_odd(e_fl_odd[sel_idx]),
      .res(res), .paddr(lk_paddr), .writable(lk_writable)
   );

   assign lk_result = res;

   // R1/R2: with no comparator firing, the permission stage must report a miss
   a_r2_miss_follows_compare: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec == '0) |-> (lk_result == RES_NOMATCH));

   // R9: write permission only accompanies a clean translation
   a_r9_write_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      lk_writable |-> (lk_result == RES_MATCH));

   // R8: no address leaks out on a fault or a miss
   a_r8_quiet_paddr: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_result != RES_MATCH) |-> (lk_paddr == '0));

   // R10: the picker never selects more than one entry, and only a hitting one
   a_r10_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_oh) && ((sel_oh & ~hit_vec) == '0));

endmodule

// File: tb/tlbpp_lookup_bench.sv
module tlbpp_lookup_bench;
   localparam int CLK_P = 10;
   localparam int N     = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_vpn = '0, wr_pmask = '0, wr_pfn_even = '0, wr_pfn_odd = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_global = 1'b0, wr_hkill = 1'b0;
   logic [3:0]  wr_flags_even = '0, wr_flags_odd = '0;
   logic [31:0] lk_vaddr = '0;
   logic [1:0]  lk_acc = '0;
   logic [7:0]  lk_asid = '0;
   logic [2:0]  lk_result;
   logic [31:0] lk_paddr;
   logic        lk_writable;

   always #(CLK_P/2) clk = ~clk;

   tlbpp_lookup u_tlbpp_lookup (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_vpn(wr_vpn), .wr_pmask(wr_pmask), .wr_asid(wr_asid),
      .wr_global(wr_global), .wr_hkill(wr_hkill),
      .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
      .wr_flags_even(wr_flags_even), .wr_flags_odd(wr_flags_odd),
      .lk_vaddr(lk_vaddr), .lk_acc(lk_acc), .lk_asid(lk_asid),
      .lk_result(lk_result), .lk_paddr(lk_paddr), .lk_writable(lk_writable)
   );

   // Reference model state
   logic [31:0] m_vpn [N], m_pm [N], m_pe [N], m_po [N];
   logic [7:0]  m_asid [N];
   logic        m_g [N], m_k [N];
   logic [3:0]  m_fe [N], m_fo [N];

   typedef struct {
      logic [2:0]  res;
      logic [31:0] pa;
      logic        wr;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic ref_lookup(input logic [31:0] va, input logic [1:0] acc,
                             input logic [7:0] asid, output exp_t e);
      int hit = -1;
      logic [31:0] em;
      logic        odd;
      logic [3:0]  f;
      logic [31:0] b;
      for (int i = 0; i < N; i++) begin
         em = m_pm[i] | 32'h1FFF;
         if (hit < 0 && !m_k[i] && (m_g[i] || m_asid[i] == asid) &&
             ((va & ~em) == (m_vpn[i] & ~em)))
            hit = i;
      end
      e.pa = '0; e.wr = 1'b0;
      if (hit < 0) begin
         e.res = 3'd1;
      end else begin
         em  = m_pm[hit] | 32'h1FFF;
         odd = |(va & em & ~(em >> 1));
         f   = odd ? m_fo[hit] : m_fe[hit];
         b   = odd ? m_po[hit] : m_pe[hit];
         if (!f[0])                    e.res = 3'd2;
         else if (acc == 2'd0 && f[3]) e.res = 3'd5;
         else if (acc == 2'd1 && f[2]) e.res = 3'd4;
         else if (acc == 2'd2 && !f[1]) e.res = 3'd3;
         else begin
            e.res = 3'd0;
            e.pa  = b | (va & (em >> 1));
            e.wr  = f[1];
         end
      end
   endtask

   task automatic write_entry(input int idx, input logic [31:0] vpn, input logic [31:0] pm,
                              input logic [7:0] asid, input logic g, input logic k,
                              input logic [31:0] pe, input logic [31:0] po,
                              input logic [3:0] fe, input logic [3:0] fo);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn = vpn; wr_pmask = pm; wr_asid = asid;
      wr_global = g; wr_hkill = k; wr_pfn_even = pe; wr_pfn_odd = po;
      wr_flags_even = fe; wr_flags_odd = fo;
      m_vpn[idx] = vpn; m_pm[idx] = pm; m_asid[idx] = asid; m_g[idx] = g; m_k[idx] = k;
      m_pe[idx] = pe; m_po[idx] = po; m_fe[idx] = fe; m_fo[idx] = fo;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   // Driver: present a lookup and queue the expected outcome
   task automatic lookup(input logic [31:0] va, input logic [1:0] acc,
                         input logic [7:0] asid, input string tag);
      exp_t e;
      @(negedge clk);
      lk_vaddr = va; lk_acc = acc; lk_asid = asid;
      ref_lookup(va, acc, asid, e);
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   // Monitor: compare a quarter period after the driving edge
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (lk_result !== e.res || lk_paddr !== e.pa || lk_writable !== e.wr) begin
               n_fail++;
               $display("FAIL %s: result %0d exp %0d, paddr %h exp %h, writable %0b exp %0b",
                        e.tag, lk_result, e.res, lk_paddr, e.pa, lk_writable, e.wr);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_vpn[i] = '0; m_pm[i] = '0; m_pe[i] = '0; m_po[i] = '0; m_asid[i] = '0;
         m_g[i] = 1'b0; m_k[i] = 1'b1; m_fe[i] = '0; m_fo[i] = '0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      lookup(32'h0040_0123, 2'd1, 8'd5, "R1 reset miss");
      lookup(32'h0000_0000, 2'd0, 8'd0, "R1 reset miss addr0");

      write_entry(0, 32'h0040_0000, 32'h0, 8'd5, 1'b0, 1'b0,
                  32'h1000_0000, 32'h2000_0000, 4'h3, 4'h1);
      lookup(32'h0040_0123, 2'd1, 8'd5, "R8 R11 even load");
      lookup(32'h0040_1ABC, 2'd1, 8'd5, "R4 R9 odd load");
      lookup(32'h0040_1ABC, 2'd2, 8'd5, "R7 odd store dirty");
      lookup(32'h0040_0ABC, 2'd2, 8'd5, "R9 even store");
      lookup(32'h0040_0123, 2'd1, 8'd6, "R2 asid mismatch");
      lookup(32'h0040_2000, 2'd1, 8'd5, "R3 outside pair");

      write_entry(1, 32'h0080_0000, 32'h0, 8'd9, 1'b1, 1'b0,
                  32'h3000_0000, 32'h3000_1000, 4'h5, 4'hB);
      lookup(32'h0080_0040, 2'd1, 8'd1, "R6 R2 global load read-inhibit");
      lookup(32'h0080_0040, 2'd0, 8'd1, "R6 fetch ignores read-inhibit");
      lookup(32'h0080_0040, 2'd2, 8'd1, "R6 R7 store ignores read-inhibit");
      lookup(32'h0080_1040, 2'd0, 8'd1, "R6 fetch execute-inhibit");
      lookup(32'h0080_1040, 2'd1, 8'd1, "R6 R9 load ignores execute-inhibit");
      lookup(32'h0080_1040, 2'd2, 8'd1, "R6 store ignores execute-inhibit");

      write_entry(2, 32'h0100_0000, 32'h0001_E000, 8'd0, 1'b1, 1'b0,
                  32'h0, 32'h4000_0000, 4'h8, 4'h3);
      lookup(32'h0100_0004, 2'd2, 8'd3, "R5 invalid half");
      lookup(32'h0100_0004, 2'd0, 8'd3, "R5 invalid before execute-inhibit");
      lookup(32'h0101_2345, 2'd1, 8'd3, "R3 R4 R8 wide odd");
      lookup(32'h0100_E000, 2'd1, 8'd3, "R3 wide mask bits ignored");
      lookup(32'h0102_0000, 2'd1, 8'd3, "R3 wide pair miss");

      write_entry(3, 32'h0500_0000, 32'h0, 8'd0, 1'b1, 1'b1,
                  32'h7000_0000, 32'h7000_0000, 4'hF & 4'h3, 4'h3);
      lookup(32'h0500_0010, 2'd1, 8'd0, "R2 killed entry");

      write_entry(5, 32'h0600_0000, 32'h0, 8'd0, 1'b1, 1'b0,
                  32'h6000_0000, 32'h6000_0000, 4'h1, 4'h1);
      write_entry(4, 32'h0600_0000, 32'h0, 8'd0, 1'b1, 1'b0,
                  32'h5000_0000, 32'h5000_0000, 4'h3, 4'h3);
      lookup(32'h0600_0777, 2'd2, 8'd0, "R10 lowest index wins");
      write_entry(4, 32'h0600_0000, 32'h0, 8'd0, 1'b1, 1'b1,
                  32'h5000_0000, 32'h5000_0000, 4'h3, 4'h3);
      lookup(32'h0600_0777, 2'd2, 8'd0, "R10 R11 rewrite exposes next");
      lookup(32'h0600_0777, 2'd1, 8'd0, "R10 R11 next entry load");

      for (int it = 0; it < 600; it++) begin
         if ($urandom_range(0, 3) == 0) begin
            logic [31:0] pm;
            pm = ($urandom_range(0, 1) == 1) ? 32'h0001_E000 : 32'h0;
            write_entry($urandom_range(0, N-1),
                        32'h0100_0000 + (32'($urandom_range(0, 7)) << 17) +
                           (pm == 0 ? (32'($urandom_range(0, 15)) << 13) : 32'h0),
                        pm, 8'($urandom_range(1, 3)), 1'($urandom_range(0, 1)),
                        ($urandom_range(0, 7) == 0),
                        $urandom & 32'hFFFE_0000, $urandom & 32'hFFFE_0000,
                        4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
         end else begin
            lookup(32'h0100_0000 + (32'($urandom_range(0, 7)) << 17) +
                      32'($urandom_range(0, 32'h1FFFF)),
                   2'($urandom_range(0, 2)), 8'($urandom_range(1, 3)),
                   "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
         end
      end

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule